// File: doc/BRIEF.md
# Frame Pass Gate with Line Checks

This block sits between a video path that holds at most one line and the packet output toward a CSI-2 transmitter. It follows frame start, line end and frame end events from the video side. For each frame it counts lines, checks that every line has the same length as the first line of that frame, and records parity error pulses. At frame end it compares the line count with the count of the frame before. Any difference, including a frame with no lines after normal video, sets a sticky line-count-changed flag.

A four-bit enable word chooses which checks can pull the pass signal low. Once pass is low, every packet that starts is dropped whole. Pass comes back after enough consecutive clean frames. The block only sees one line at a time, so it can only react after a frame has ended. Packets of the faulty frame that were already sent, including its frame start and frame end short packets, are not withdrawn. Dropping begins with the first packet that starts after the decision.

The packet stream passes through with one cycle of latency. The video events are only observed and are never changed.

Top module: `frame_pass_gate`

## Requirements
- R1: After reset, `pass_o` is 1, `lcc_o` is 0 and `out_valid` is 0.
- R2: The first frame end after reset stores its line count as the reference and never sets `lcc_o`.
- R3: At a frame end whose line count differs from the previous frame's count (zero lines included), `lcc_o` becomes 1 in the following cycle. It stays 1 until a cycle with `lcc_clr_i` high, which clears it. A new change in the same cycle as the clear leaves it at 1.
- R4: A frame is size-bad if any of its lines has a `line_len_i` different from the first line of that frame. A frame is parity-bad if `perr_i` pulses between its start and its end.
- R5: `cfg_en` bit 0 enables the line-count check, bit 1 the line-size check and bit 2 the parity check. If an enabled check fails at a frame end, `pass_o` is 0 from the next cycle on. A failed check that is disabled leaves `pass_o` unchanged. `pass_o` changes only at frame ends.
- R6: While `pass_o` is 0 and `cfg_en` bit 3 is 1, `pass_o` returns after `cfg_thr`+1 consecutive clean frame ends, so a threshold of 0 returns it on the next clean frame. A bad frame restarts the count. With bit 3 at 0, the first clean frame end returns it.
- R7: A packet whose first word (`in_sop`) arrives while `pass_o` is 0 is dropped in every word.
- R8: A packet whose first word arrives while `pass_o` is 1 is forwarded in every word, even if `pass_o` falls before its last word. Forwarded words appear on the outputs one cycle after the input, with the same data and framing.
- R9: A packet that starts in the same cycle as the frame end event, or earlier, is judged by the pass value from before that frame's evaluation. The frame start and frame end packets of a bad frame are therefore still sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 4 | Check enables: [0] count, [1] size, [2] parity, [3] threshold |
| cfg_thr | input | 2 | Clean-frame threshold minus one |
| lcc_clr_i | input | 1 | Clear strobe for the line-count-changed flag |
| fs_i | input | 1 | Frame start event pulse |
| le_i | input | 1 | Line end event pulse |
| line_len_i | input | LEN_W | Length of the line ending, valid with `le_i` |
| perr_i | input | 1 | Parity error pulse |
| fe_i | input | 1 | Frame end event pulse |
| in_valid | input | 1 | Input packet word valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | DATA_W | Input packet word |
| out_valid | output | 1 | Output packet word valid |
| out_sop | output | 1 | Output first word |
| out_eop | output | 1 | Output last word |
| out_data | output | DATA_W | Output packet word |
| pass_o | output | 1 | Pass state |
| lcc_o | output | 1 | Sticky line-count-changed flag |

## Verification
The assertions assume well-formed input. `fs_i`, `le_i` and `fe_i` are never high in the same cycle. `perr_i` does not coincide with `fs_i`. Packets are marked with one `in_sop` and one `in_eop` and do not interleave. The bench builds every frame from these events one at a time, with gaps between them. It sends each packet as a complete sop..eop sequence, sometimes overlapping a frame end so that the gate's decision is tested in the middle of a packet. Line counts, length mismatches, parity pulses, enables, thresholds and clear strobes are drawn at random from a fixed seed.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  localparam int THR_W   = 2;
  localparam int RUN_W   = THR_W + 1;
  localparam int EN_W    = 4;
  localparam int EN_CNT  = 0;
  localparam int EN_SIZE = 1;
  localparam int EN_PAR  = 2;
  localparam int EN_THR  = 3;

  typedef struct packed {
    logic cnt_chg;
    logic size_bad;
    logic par_bad;
  } frm_verdict_t;

  // A frame is rejected when any enabled check reports a failure.
  function automatic logic verdict_bad(input frm_verdict_t v, input logic [EN_W-1:0] en);
    return (en[EN_CNT] & v.cnt_chg) | (en[EN_SIZE] & v.size_bad) | (en[EN_PAR] & v.par_bad);
  endfunction

  // Number of consecutive clean frames needed before pass returns.
  function automatic logic [RUN_W-1:0] clean_target(input logic [THR_W-1:0] thr);
    return RUN_W'(thr) + RUN_W'(1);
  endfunction

  function automatic logic run_complete(input logic [RUN_W-1:0] run_next,
                                        input logic [THR_W-1:0] thr);
    return run_next >= clean_target(thr);
  endfunction
endpackage

// File: rtl/fpg_line_tracker.sv
module fpg_line_tracker #(
  parameter int LEN_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_i,
  input  logic             le_i,
  input  logic [LEN_W-1:0] line_len_i,
  input  logic             perr_i,
  input  logic             fe_i,
  output logic             frm_eval_o,
  output logic [CNT_W-1:0] lines_o,
  output logic             size_bad_o,
  output logic             par_bad_o
);
  logic             in_frame_q;
  logic [CNT_W-1:0] line_cnt_q;
  logic [LEN_W-1:0] first_len_q;
  logic             have_first_q;
  logic             size_err_q;
  logic             par_err_q;

  // Named internal events.
  logic line_seen;
  logic len_mismatch;
  logic par_seen;

  assign line_seen    = le_i & in_frame_q;
  assign len_mismatch = line_seen & have_first_q & (line_len_i != first_len_q);
  assign par_seen     = perr_i & in_frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q   <= 1'b0;
      line_cnt_q   <= '0;
      first_len_q  <= '0;
      have_first_q <= 1'b0;
      size_err_q   <= 1'b0;
      par_err_q    <= 1'b0;
    end else if (fs_i) begin
      in_frame_q   <= 1'b1;
      line_cnt_q   <= '0;
      have_first_q <= 1'b0;
      size_err_q   <= 1'b0;
      par_err_q    <= 1'b0;
    end else begin
      if (line_seen) begin
        line_cnt_q <= line_cnt_q + 1'b1;
        if (!have_first_q) begin
          first_len_q  <= line_len_i;
          have_first_q <= 1'b1;
        end
      end
      if (len_mismatch) size_err_q <= 1'b1;
      if (par_seen)     par_err_q  <= 1'b1;
      if (fe_i)         in_frame_q <= 1'b0;
    end
  end

  assign frm_eval_o = fe_i & in_frame_q;
  assign lines_o    = line_cnt_q;
  assign size_bad_o = size_err_q;
  assign par_bad_o  = par_err_q | par_seen;

  AST_FS_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) fs_i |=> (line_cnt_q == '0)); // R3
  AST_SIZE_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (size_err_q && !fs_i) |=> size_err_q); // R4
  AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (len_mismatch && !fs_i) |=> size_err_q); // R4
endmodule

// File: rtl/fpg_count_monitor.sv
module fpg_count_monitor #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_eval_i,
  input  logic [CNT_W-1:0] lines_i,
  input  logic             clr_i,
  output logic             cnt_chg_o,
  output logic             lcc_o
);
  logic [CNT_W-1:0] ref_cnt_q;
  logic             ref_valid_q;
  logic             lcc_q;

  assign cnt_chg_o = frm_eval_i & ref_valid_q & (lines_i != ref_cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt_q   <= '0;
      ref_valid_q <= 1'b0;
      lcc_q       <= 1'b0;
    end else begin
      if (frm_eval_i) begin
        ref_cnt_q   <= lines_i;
        ref_valid_q <= 1'b1;
      end
      // A new change takes precedence over a clear in the same cycle.
      if (cnt_chg_o)  lcc_q <= 1'b1;
      else if (clr_i) lcc_q <= 1'b0;
    end
  end

  assign lcc_o = lcc_q;

  AST_FIRST_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (frm_eval_i && !ref_valid_q && !lcc_q && !clr_i) |=> !lcc_q); // R2
  AST_LCC_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (lcc_q && !clr_i) |=> lcc_q); // R3
  AST_LCC_SET: assert property (@(posedge clk) disable iff (!rst_n) cnt_chg_o |=> lcc_q); // R3
  AST_LCC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !cnt_chg_o) |=> !lcc_q); // R3
endmodule

// File: rtl/fpg_pass_ctrl.sv
module fpg_pass_ctrl
  import fpg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_eval_i,
  input  frm_verdict_t       verdict_i,
  input  logic [EN_W-1:0]    cfg_en,
  input  logic [THR_W-1:0]   cfg_thr,
  output logic               pass_o
);
  logic             pass_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_next;

  // Named internal events.
  logic frame_bad;
  logic frame_clean;
  logic recover;

  assign frame_bad   = frm_eval_i & verdict_bad(verdict_i, cfg_en);
  assign frame_clean = frm_eval_i & ~verdict_bad(verdict_i, cfg_en);
  assign run_next    = run_q + 1'b1;
  assign recover     = frame_clean & ~pass_q &
                       (~cfg_en[EN_THR] | run_complete(run_next, cfg_thr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_q <= 1'b1;
      run_q  <= '0;
    end else if (frame_bad) begin
      pass_q <= 1'b0;
      run_q  <= '0;
    end else if (recover) begin
      pass_q <= 1'b1;
      run_q  <= '0;
    end else if (frame_clean && !pass_q) begin
      run_q  <= run_next;
    end
  end

  assign pass_o = pass_q;

  AST_BAD_DROPS_PASS: assert property (@(posedge clk) disable iff (!rst_n) frame_bad |=> !pass_q); // R5
  AST_PASS_AT_EVAL: assert property (@(posedge clk) disable iff (!rst_n) !frm_eval_i |=> $stable(pass_q)); // R5
  AST_RISE_ON_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) $rose(pass_q) |-> $past(frame_clean)); // R6
  AST_NOTHR_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n) (frame_clean && !cfg_en[EN_THR]) |=> pass_q); // R6
endmodule

// File: rtl/fpg_pkt_gate.sv
module fpg_pkt_gate #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pass_i,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data
);
  logic fwd_active_q;
  logic keep_word;

  // The decision is taken at the first word and held for the whole packet.
  assign keep_word = in_sop ? pass_i : fwd_active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_active_q <= 1'b0;
      out_valid    <= 1'b0;
      out_sop      <= 1'b0;
      out_eop      <= 1'b0;
      out_data     <= '0;
    end else begin
      if (in_valid) begin
        if (in_sop)      fwd_active_q <= pass_i & ~in_eop;
        else if (in_eop) fwd_active_q <= 1'b0;
      end
      out_valid <= in_valid & keep_word;
      out_sop   <= in_valid & keep_word & in_sop;
      out_eop   <= in_valid & keep_word & in_eop;
      out_data  <= in_data;
    end
  end

  AST_DROP_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_sop && !pass_i) |=> !out_valid); // R7
  AST_START_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_sop && pass_i) |=> (out_valid && out_sop)); // R8
  AST_NO_MID_CUT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_sop && fwd_active_q) |=> out_valid); // R8
  AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> (out_data == $past(in_data))); // R8
endmodule

// File: rtl/frame_pass_gate.sv
module frame_pass_gate
  import fpg_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_en,
  input  logic [1:0]        cfg_thr,
  input  logic              lcc_clr_i,
  input  logic              fs_i,
  input  logic              le_i,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic              perr_i,
  input  logic              fe_i,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DATA_W-1:0] out_data,
  output logic              pass_o,
  output logic              lcc_o
);
  logic             frm_eval;
  logic [CNT_W-1:0] frm_lines;
  logic             size_bad;
  logic             par_bad;
  logic             cnt_chg;
  frm_verdict_t     verdict;
  logic             pass_w;

  fpg_line_tracker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_i       (fs_i),
    .le_i       (le_i),
    .line_len_i (line_len_i),
    .perr_i     (perr_i),
    .fe_i       (fe_i),
    .frm_eval_o (frm_eval),
    .lines_o    (frm_lines),
    .size_bad_o (size_bad),
    .par_bad_o  (par_bad)
  );

  fpg_count_monitor #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_eval_i (frm_eval),
    .lines_i    (frm_lines),
    .clr_i      (lcc_clr_i),
    .cnt_chg_o  (cnt_chg),
    .lcc_o      (lcc_o)
  );

  assign verdict.cnt_chg  = cnt_chg;
  assign verdict.size_bad = size_bad;
  assign verdict.par_bad  = par_bad;

  fpg_pass_ctrl u_pass (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_eval_i (frm_eval),
    .verdict_i  (verdict),
    .cfg_en     (cfg_en),
    .cfg_thr    (cfg_thr),
    .pass_o     (pass_w)
  );

  fpg_pkt_gate #(.DATA_W(DATA_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pass_i    (pass_w),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data)
  );

  assign pass_o = pass_w;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $countones({fs_i, le_i, fe_i}) <= 1); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (pass_o && !lcc_o && !out_valid)); // R1
endmodule

// File: tb/frame_pass_gate_tb_top.sv
module frame_pass_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = 12;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [3:0]        cfg_en = 4'b0000;
  logic [1:0]        cfg_thr = 2'd0;
  logic              lcc_clr_i = 1'b0;
  logic              fs_i = 1'b0, le_i = 1'b0, perr_i = 1'b0, fe_i = 1'b0;
  logic [LEN_W-1:0]  line_len_i = '0;
  logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid, out_sop, out_eop, pass_o, lcc_o;
  logic [DATA_W-1:0] out_data;

  frame_pass_gate #(.LEN_W(LEN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_thr(cfg_thr), .lcc_clr_i(lcc_clr_i),
    .fs_i(fs_i), .le_i(le_i), .line_len_i(line_len_i), .perr_i(perr_i), .fe_i(fe_i),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .pass_o(pass_o), .lcc_o(lcc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Reference model state.
  bit m_pass = 1, m_lcc = 0, m_refv = 0;
  int m_ref = 0, m_run = 0;

  function automatic int frames_needed(int thr);
    int need = 1;
    for (int k = 0; k < thr; k++) need++;
    return need;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    fs_i = 0; le_i = 0; perr_i = 0; fe_i = 0; lcc_clr_i = 0;
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic expect_word(input bit exp, input logic [DATA_W-1:0] d,
                             input bit sop, input bit eop, input string req);
    chk(out_valid == exp, req, out_valid, exp);
    if (exp) begin
      chk(out_data == d, req, out_data, d);
      chk({out_sop, out_eop} == {sop, eop}, req, {out_sop, out_eop}, {sop, eop});
    end
  endtask

  task automatic model_eval(input int n, input bit sz, input bit pb, input bit clr);
    bit chg, bad;
    chg = m_refv && (n != m_ref);
    m_lcc = (m_lcc && !clr) || chg;
    m_ref = n; m_refv = 1;
    bad = (cfg_en[0] && chg) || (cfg_en[1] && sz) || (cfg_en[2] && pb);
    if (bad) begin
      m_pass = 0; m_run = 0;
    end else if (!m_pass) begin
      if (!cfg_en[3]) begin
        m_pass = 1; m_run = 0;
      end else begin
        m_run++;
        if (m_run >= frames_needed(int'(cfg_thr))) begin
          m_pass = 1; m_run = 0;
        end
      end
    end
  endtask

  task automatic check_state(input string req);
    chk(pass_o == m_pass, req, pass_o, m_pass);
    chk(lcc_o == m_lcc, "R3 lcc flag", lcc_o, m_lcc);
  endtask

  task automatic run_frame(input int n, input bit sz, input bit pb, input bit clr_fe,
                           input bit long_fe, input string req);
    int blen;
    bit fwd;
    logic [DATA_W-1:0] d;
    blen = 8 + int'($urandom_range(0, 7));
    fwd = m_pass;
    d = $urandom; fs_i = 1; in_valid = 1; in_sop = 1; in_eop = 1; in_data = d;
    tick(); expect_word(fwd, d, 1, 1, "R9 frame start packet");
    for (int i = 0; i < n; i++) begin
      d = $urandom; in_valid = 1; in_sop = 1; in_data = d;
      tick(); expect_word(fwd, d, 1, 0, "R7 line head");
      d = $urandom; in_valid = 1; in_eop = 1; in_data = d; le_i = 1;
      line_len_i = LEN_W'(blen + ((sz && i == n - 1) ? 1 : 0));
      tick(); expect_word(fwd, d, 0, 1, "R7 line tail");
    end
    if (pb) begin perr_i = 1; tick(); end
    if (long_fe) begin
      d = $urandom; in_valid = 1; in_sop = 1; in_data = d;
      tick(); expect_word(fwd, d, 1, 0, "R8 head before frame end");
      d = $urandom; in_valid = 1; in_data = d; fe_i = 1; lcc_clr_i = clr_fe;
      tick(); expect_word(fwd, d, 0, 0, "R9 word at frame end");
      model_eval(n, sz, pb, clr_fe); check_state(req);
      d = $urandom; in_valid = 1; in_eop = 1; in_data = d;
      tick(); expect_word(fwd, d, 0, 1, "R8 tail after decision");
    end else begin
      d = $urandom; fe_i = 1; lcc_clr_i = clr_fe;
      in_valid = 1; in_sop = 1; in_eop = 1; in_data = d;
      tick(); expect_word(fwd, d, 1, 1, "R9 frame end packet");
      model_eval(n, sz, pb, clr_fe); check_state(req);
    end
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int last_n;
    logic [DATA_W-1:0] d;
    void'($urandom(32'h5EED_0042));
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(pass_o == 1, "R1 reset pass", pass_o, 1);
    chk(lcc_o == 0, "R1 reset lcc", lcc_o, 0);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    rst_n = 1;
    tick();

    cfg_en = 4'b1111; cfg_thr = 2'd2;
    run_frame(4, 0, 0, 0, 0, "R2 first frame no flag");
    run_frame(4, 0, 0, 0, 0, "R5 clean frame keeps pass");
    run_frame(0, 0, 0, 0, 0, "R3 R5 zero lines after video");
    lcc_clr_i = 1; tick(); m_lcc = 0;
    chk(lcc_o == 0, "R3 clear strobe", lcc_o, 0);
    run_frame(0, 0, 0, 0, 0, "R6 one clean of three");
    run_frame(0, 0, 0, 0, 0, "R6 two clean of three");
    run_frame(0, 0, 0, 0, 0, "R6 third clean returns pass");

    cfg_en = 4'b0010;
    run_frame(3, 0, 0, 0, 0, "R5 disabled count check ignored");
    run_frame(3, 1, 0, 0, 0, "R4 R5 size mismatch drops");
    run_frame(3, 0, 0, 0, 0, "R6 no threshold recovers");

    cfg_en = 4'b1100; cfg_thr = 2'd1;
    run_frame(3, 0, 1, 0, 0, "R4 R5 parity drops");
    run_frame(3, 0, 0, 0, 0, "R6 first clean of two");
    run_frame(3, 0, 1, 0, 0, "R6 bad frame restarts run");
    run_frame(3, 0, 0, 0, 0, "R6 clean after restart");
    run_frame(3, 0, 0, 0, 0, "R6 second clean returns pass");
    cfg_thr = 2'd0;
    run_frame(3, 0, 1, 0, 0, "R5 parity drop again");
    run_frame(3, 0, 0, 0, 0, "R6 threshold zero next clean");

    cfg_en = 4'b0000;
    run_frame(5, 0, 0, 1, 0, "R3 set wins over clear");

    cfg_en = 4'b0001;
    run_frame(2, 0, 0, 0, 1, "R8 R5 drop during packet");
    d = $urandom; in_valid = 1; in_sop = 1; in_data = d;
    tick(); expect_word(0, d, 1, 0, "R7 head dropped while low");
    d = $urandom; in_valid = 1; in_eop = 1; in_data = d;
    tick(); expect_word(0, d, 0, 1, "R7 tail dropped while low");

    last_n = 2;
    for (int f = 0; f < 300; f++) begin
      int n;
      bit sz, pb, clr_fe, long_fe;
      if (f % 10 == 0) begin
        cfg_en  = 4'($urandom_range(0, 15));
        cfg_thr = 2'($urandom_range(0, 3));
      end
      n = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 6)) : last_n;
      sz = (n >= 2) && ($urandom_range(0, 5) == 0);
      pb = ($urandom_range(0, 5) == 0);
      clr_fe = ($urandom_range(0, 7) == 0);
      long_fe = ($urandom_range(0, 4) == 0);
      run_frame(n, sz, pb, clr_fe, long_fe, "R5 R6 random frame");
      last_n = n;
      if ($urandom_range(0, 6) == 0) begin
        lcc_clr_i = 1; tick(); m_lcc = 0;
        chk(lcc_o == 0, "R3 random clear", lcc_o, 0);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule